// File: doc/BRIEF.md
# Main Clock Loss Reset Monitor

This block watches a fast main system clock from a separate, always-running reference oscillator and raises an internal reset request when the main clock falls silent. The main clock toggles a flag in its own domain. That flag is carried into the reference domain through a flop synchronizer, and each change seen there counts as one main-clock edge. A reference-domain timeout counter clears on every observed edge. When it runs through its window with no edge, the block issues a one-cycle reset pulse and sets a sticky cause flag. Software reads that flag after restart to learn that clock loss caused the reset.

Monitoring pauses on its own whenever main-clock silence is legitimate:
- software has not enabled it;
- the reference oscillator is reported off;
- the device is in STOP mode;
- software has stopped the main oscillator or selected away from it;
- the oscillation stabilization period has not yet finished.

After reset, or after any stop cause is released, monitoring stays paused until the stabilization status is seen to rise again. While paused, the timeout counter is held at zero.

Top module: `osc_loss_monitor`

## Requirements
- R1: While `rst_n` is low and on the cycle after it goes high, `loss_rst` and `loss_flag` are 0. After reset, no loss is declared until `stab_done` has been sampled at 0 and then at 1 (a rising edge) in the reference domain.
- R2: While the main clock keeps toggling, `loss_rst` stays 0.
- R3: Once the main clock stops with monitoring active, `loss_rst` goes high between TIMEOUT+1 and TIMEOUT+SYNC_STAGES+3 reference cycles after the stop. A stop lasting fewer reference cycles than TIMEOUT produces no pulse.
- R4: `loss_rst` is high for exactly one reference cycle per loss event. A second pulse needs a new observed main edge, or a suspension, before the next silent window.
- R5: `loss_flag` goes to 1 in the same cycle as `loss_rst`. It stays 1 until a cycle with `flag_clr`=1, which clears it on the next edge. When a set and a clear coincide, the set wins. `rst_n` low also clears it.
- R6: With `mon_en`=0, no loss is declared.
- R7: With `ref_osc_on`=0, no loss is declared.
- R8: `stop_mode`=1, `osc_stop_sw`=1 or `clk_sel_sw`=1 each suspend monitoring. After the cause is released, monitoring stays suspended until a new rising edge of `stab_done` is seen, even if `stab_done` stayed 1 throughout.
- R9: With `stab_done`=0, no loss is declared.
- R10: While suspended, the timeout counter is held at zero. When monitoring resumes by `mon_en` going 1 with the main clock already stopped, `loss_rst` rises exactly TIMEOUT reference cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference oscillator clock; all control logic runs here |
| main_clk | input | 1 | Monitored main system clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| mon_en | input | 1 | Software monitor enable, 1 = monitor |
| ref_osc_on | input | 1 | 1 = reference oscillator running |
| stop_mode | input | 1 | 1 = device in STOP mode |
| osc_stop_sw | input | 1 | 1 = software has stopped the main oscillator |
| clk_sel_sw | input | 1 | 1 = software has switched away from the main clock |
| stab_done | input | 1 | Stabilization counter overflow status, 1 = oscillation stable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the cause flag |
| loss_rst | output | 1 | One-cycle reset request on main clock loss |
| loss_flag | output | 1 | Sticky clock-loss reset cause flag |

## Verification
The bench builds the block with TIMEOUT=4 and SYNC_STAGES=2. The timeout window is therefore a handful of reference cycles, and the exact resume latency of R10 can be checked cycle by cycle. Each silent window spans several full timeout periods, which shows the one-pulse-per-event rule and the re-arm after a fresh edge. With a short window, the latency range of R3 can be measured precisely, and each suspension cause can be tested in turn, including its release while `stab_done` stays high.

// File: rtl/osc_mon_pkg.sv
// Shared types and helpers for the main clock loss monitor.
package osc_mon_pkg;

    // Bundle of control inputs that decide whether monitoring is allowed.
    typedef struct packed {
        logic enable;
        logic ref_running;
        logic stop_mode;
        logic osc_stop;
        logic clk_select;
        logic stab_done;
    } mon_ctrl_t;

    // Counter width that holds values 0 .. limit-1.
    function automatic int cnt_width(input int limit);
        return (limit < 3) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/osc_mon_edge_sync.sv
// Main clock activity detector.
// Toggles a flag on every main clock edge, brings it into the reference
// domain through SYNC_STAGES flops and reports one pulse per observed change.
// Assumes rst_n is held long enough for several main clock edges while the
// main clock runs; if the main clock is dead in reset, the flag stays put.
module osc_mon_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic main_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic main_edge
);
    localparam int LAST = SYNC_STAGES - 1;

    logic             main_tgl;
    logic [LAST:0]    sync_q;
    logic             seen_q;

    // Purpose: flip the activity flag on every main clock edge.
    always_ff @(posedge main_clk) begin
        if (!rst_n) main_tgl <= 1'b0;
        else        main_tgl <= ~main_tgl;
    end

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous flag.
                always_ff @(posedge ref_clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= main_tgl;
                end
            end else begin : g_next
                // Purpose: further settling stage.
                always_ff @(posedge ref_clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Purpose: remember the last settled value to spot changes.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= sync_q[LAST];
    end

    assign main_edge = sync_q[LAST] ^ seen_q;

    // R2: an observed edge is always followed by the settled value holding.
    p_edge_settles_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        main_edge |=> (seen_q == $past(sync_q[LAST])));

endmodule

// File: rtl/osc_mon_gate.sv
// Suspension logic for the clock loss monitor.
// Combines the software, power-mode and oscillator status inputs into one
// suspend signal. After reset or any stop cause, it waits for a fresh rising
// edge of the stabilization status. Assumes all inputs are synchronous to
// ref_clk.
module osc_mon_gate
    import osc_mon_pkg::*;
(
    input  logic      ref_clk,
    input  logic      rst_n,
    input  mon_ctrl_t ctrl,
    output logic      suspend
);
    logic cause;
    logic stab_prev;
    logic wait_stab;
    logic stab_rise;

    assign cause     = ctrl.stop_mode | ctrl.osc_stop | ctrl.clk_select;
    assign stab_rise = ctrl.stab_done & ~stab_prev;

    // Purpose: track the previous stabilization status for edge detection.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) stab_prev <= 1'b0;
        else        stab_prev <= ctrl.stab_done;
    end

    // Purpose: hold off monitoring until stabilization completes anew.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)         wait_stab <= 1'b1;
        else if (cause)     wait_stab <= 1'b1;
        else if (stab_rise) wait_stab <= 1'b0;
    end

    assign suspend = ~ctrl.enable | ~ctrl.ref_running | cause
                   | wait_stab | ~ctrl.stab_done;

    // R8: releasing a stop cause never resumes monitoring in the same cycle.
    p_hold_after_cause_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(cause) |-> suspend);

    // R9: resuming only happens with stabilization reported complete.
    p_resume_needs_stab_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(suspend) |-> ctrl.stab_done);

endmodule

// File: rtl/osc_mon_timer.sv
// Timeout counter for the clock loss monitor.
// Counts active reference cycles without an observed main edge. It fires
// once when TIMEOUT such cycles have passed and re-arms on a new edge or a
// suspension. Assumes TIMEOUT >= 2.
module osc_mon_timer
    import osc_mon_pkg::*;
#(
    parameter int TIMEOUT = 4
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic suspend,
    input  logic main_edge,
    output logic fire,
    output logic loss_pulse
);
    localparam int              CNT_W = cnt_width(TIMEOUT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt;
    logic             fired;

    assign fire = ~suspend & ~main_edge & ~fired & (cnt == LAST);

    // Purpose: count silent active cycles, saturating at the last value.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || suspend || main_edge) cnt <= '0;
        else if (cnt != LAST)               cnt <= cnt + CNT_W'(1);
    end

    // Purpose: allow one pulse per loss event until re-armed.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || suspend || main_edge) fired <= 1'b0;
        else if (fire)                      fired <= 1'b1;
    end

    // Purpose: register the reset request as a one-cycle pulse.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) loss_pulse <= 1'b0;
        else        loss_pulse <= fire;
    end

    // R4: the reset request never lasts two cycles.
    p_pulse_one_cycle_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        loss_pulse |=> !loss_pulse);

    // R10: suspension forces the counter back to zero.
    p_held_zero_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        suspend |=> (cnt == '0));

    // R10: no pulse follows a suspended cycle.
    p_no_pulse_suspended_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        loss_pulse |-> !$past(suspend));

endmodule

// File: rtl/osc_mon_flag.sv
// Sticky clock-loss cause flag.
// Set by the timer's fire strobe, cleared by a write-one strobe from
// software or by power-on reset. A set wins over a simultaneous clear.
module osc_mon_flag (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    // Purpose: hold the cause until software acknowledges it.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // R5: without a clear, a set flag stays set.
    p_flag_sticky_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

endmodule

// File: rtl/osc_loss_monitor.sv
// Top of the main clock loss reset monitor.
// Ties together the cross-domain edge detector, the suspension gate, the
// timeout counter and the sticky cause flag. All control inputs are
// assumed synchronous to ref_clk.
module osc_loss_monitor
    import osc_mon_pkg::*;
#(
    parameter int TIMEOUT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic main_clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic ref_osc_on,
    input  logic stop_mode,
    input  logic osc_stop_sw,
    input  logic clk_sel_sw,
    input  logic stab_done,
    input  logic flag_clr,
    output logic loss_rst,
    output logic loss_flag
);
    mon_ctrl_t ctrl;
    logic      main_edge;
    logic      suspend;
    logic      fire;

    assign ctrl = '{enable: mon_en, ref_running: ref_osc_on, stop_mode: stop_mode,
                    osc_stop: osc_stop_sw, clk_select: clk_sel_sw, stab_done: stab_done};

    osc_mon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .main_clk  (main_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .main_edge (main_edge)
    );

    osc_mon_gate u_gate (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .suspend (suspend)
    );

    osc_mon_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .suspend    (suspend),
        .main_edge  (main_edge),
        .fire       (fire),
        .loss_pulse (loss_rst)
    );

    osc_mon_flag u_flag (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .set_req (fire),
        .clr_req (flag_clr),
        .flag    (loss_flag)
    );

    // R5: the cause flag is set whenever the reset request is issued.
    p_flag_with_pulse_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        loss_rst |-> loss_flag);

    // R6: a disabled monitor never requests reset.
    p_disabled_quiet_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $past(!mon_en) |-> !loss_rst);

endmodule

// File: tb/osc_loss_monitor_tb_top.sv
module osc_loss_monitor_tb_top;
    localparam int TIMEOUT = 4;
    localparam int SYNC    = 2;

    logic ref_clk = 1'b0, main_clk = 1'b0, main_run = 1'b1;
    logic rst_n = 1'b0;
    logic mon_en = 1'b1, ref_osc_on = 1'b1, stop_mode = 1'b0;
    logic osc_stop_sw = 1'b0, clk_sel_sw = 1'b0, stab_done = 1'b0, flag_clr = 1'b0;
    logic loss_rst, loss_flag;

    int  checks = 0, failures = 0;
    bit  done = 0;

    osc_loss_monitor #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC)) dut_i (
        .ref_clk(ref_clk), .main_clk(main_clk), .rst_n(rst_n), .mon_en(mon_en),
        .ref_osc_on(ref_osc_on), .stop_mode(stop_mode), .osc_stop_sw(osc_stop_sw),
        .clk_sel_sw(clk_sel_sw), .stab_done(stab_done), .flag_clr(flag_clr),
        .loss_rst(loss_rst), .loss_flag(loss_flag)
    );

    always #5 ref_clk = ~ref_clk;
    always begin
        #2;
        if (main_run) main_clk = ~main_clk;
    end

    typedef struct packed {
        logic       en, ref_on, stp, ostop, csel, stab;
        logic [7:0] silent;
        logic [7:0] exp_pulses;
        logic [7:0] req;
    } vec_t;

    // Fields: en, ref_on, stop, osc_stop, clk_sel, stab, silent cycles, pulses, requirement
    localparam vec_t VECS [0:8] = '{
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd20, 8'd1, 8'd3},  // R3 normal loss
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2,  8'd0, 8'd3},  // R3 short stop
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd20, 8'd0, 8'd6},  // R6 disabled
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd20, 8'd0, 8'd7},  // R7 reference off
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd20, 8'd0, 8'd8},  // R8 STOP mode
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd20, 8'd0, 8'd8},  // R8 oscillator stop
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd20, 8'd0, 8'd8},  // R8 clock select
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd0, 8'd9},  // R9 not stable
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd40, 8'd1, 8'd4}   // R4 one pulse only
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge ref_clk);
    endtask

    task automatic count_pulses(input int n, output int pulses);
        pulses = 0;
        repeat (n) begin
            @(negedge ref_clk);
            if (loss_rst) pulses++;
        end
    endtask

    task automatic defaults_restore();
        mon_en = 1; ref_osc_on = 1; stop_mode = 0; osc_stop_sw = 0; clk_sel_sw = 0;
        main_run = 1; stab_done = 0;
        repeat (3) tick();
        stab_done = 1;
        repeat (4) tick();
        flag_clr = 1; tick(); flag_clr = 0; tick();
    endtask

    initial begin
        int p, q, lat, hit;
        // R1: reset state
        repeat (4) tick();
        check(loss_rst == 0, "R1 loss_rst in reset", loss_rst, 0);
        check(loss_flag == 0, "R1 loss_flag in reset", loss_flag, 0);
        rst_n = 1; tick();
        check(loss_rst == 0 && loss_flag == 0, "R1 outputs after reset", {loss_rst, loss_flag}, 0);
        // R1: no loss before stabilization has risen
        main_run = 0;
        count_pulses(20, p);
        check(p == 0, "R1 silent before stab rise", p, 0);
        main_run = 1; repeat (4) tick();
        stab_done = 1; repeat (4) tick();
        // R2: running main clock
        count_pulses(60, p);
        check(p == 0, "R2 running clock pulses", p, 0);

        // Vector table walk
        for (int i = 0; i < 9; i++) begin
            mon_en = VECS[i].en; ref_osc_on = VECS[i].ref_on; stop_mode = VECS[i].stp;
            osc_stop_sw = VECS[i].ostop; clk_sel_sw = VECS[i].csel; stab_done = VECS[i].stab;
            repeat (6) tick();
            main_run = 0;
            count_pulses(int'(VECS[i].silent), p);
            main_run = 1;
            count_pulses(6, q);
            check(p + q == int'(VECS[i].exp_pulses),
                  $sformatf("R%0d vector %0d pulse count", VECS[i].req, i), p + q,
                  int'(VECS[i].exp_pulses));
            if (VECS[i].exp_pulses != 0)
                check(loss_flag == 1, $sformatf("R5 flag after vector %0d", i), loss_flag, 1);
            defaults_restore();
        end

        // R3: latency from stop to pulse
        main_run = 0; lat = 0; hit = 0;
        for (int c = 1; c <= 30; c++) begin
            tick();
            if (loss_rst && hit == 0) begin hit = 1; lat = c; end
        end
        check(hit == 1 && lat >= TIMEOUT + 1 && lat <= TIMEOUT + SYNC + 3,
              "R3 stop-to-pulse latency", lat, TIMEOUT + 3);
        // R4: no second pulse while still silent
        count_pulses(20, p);
        check(p == 0, "R4 no repeat pulse", p, 0);
        // R5: flag sticky, then cleared
        check(loss_flag == 1, "R5 flag set", loss_flag, 1);
        main_run = 1; repeat (10) tick();
        check(loss_flag == 1, "R5 flag held", loss_flag, 1);
        flag_clr = 1; tick(); flag_clr = 0;
        check(loss_flag == 0, "R5 flag cleared", loss_flag, 0);
        // R4: re-armed after edges return
        repeat (4) tick();
        main_run = 0;
        count_pulses(20, p);
        check(p == 1, "R4 re-armed pulse", p, 1);
        main_run = 1; repeat (4) tick();
        flag_clr = 1; tick(); flag_clr = 0; tick();

        // R10: exact resume latency, and R5 set beats clear
        mon_en = 0; repeat (4) tick();
        main_run = 0; repeat (10) tick();
        check(loss_rst == 0 && loss_flag == 0, "R10 quiet while suspended", loss_flag, 0);
        mon_en = 1; lat = 0;
        for (int c = 1; c <= TIMEOUT + 3; c++) begin
            tick();
            if (loss_rst && lat == 0) lat = c;
            if (c == TIMEOUT) begin
                check(loss_flag == 1, "R5 set wins over clear", loss_flag, 1);
                flag_clr = 0;
            end
            if (c == TIMEOUT - 1) flag_clr = 1;
        end
        check(lat == TIMEOUT, "R10 resume to pulse cycles", lat, TIMEOUT);

        // R5: power-on reset clears the flag
        main_run = 1;
        rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
        check(loss_flag == 0, "R5 flag cleared by reset", loss_flag, 0);
        repeat (6) tick();

        // R8: release while stab_done stays high keeps suspension
        stop_mode = 1; repeat (3) tick(); stop_mode = 0;
        main_run = 0;
        count_pulses(20, p);
        check(p == 0, "R8 no resume without stab edge", p, 0);
        stab_done = 0; tick(); stab_done = 1;
        count_pulses(20, p);
        check(p == 1, "R8 resume after stab edge", p, 1);
        main_run = 1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge ref_clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule